// File: doc/BRIEF.md
# DSP Program Sequencer with Conditional Branching

This block is the program sequencer of a small fixed-point DSP core. Each cycle it takes the 24-bit instruction word that program memory returns for the current program counter. It sorts the word into one of four instruction classes and registers the next program counter. The classes are operation, operation-then-return, jump and load-immediate. The execution datapath lives elsewhere. The sequencer only sees the flag bits of the two accumulators, three status bits, the low nibble of the data pointer and an address held in a register. It uses these inputs to decide where the program goes next.

Jump words carry a 9-bit branch code. The code selects one of these actions:
- an unconditional long jump into either half of the 14-bit program space;
- a call into either half, which saves the return address on an 8-entry hardware stack;
- a jump to the register-supplied address;
- one of dozens of conditional tests.

A taken conditional jump keeps the upper-half bit of the incremented counter and inserts the bank and next-address fields below it. A return-class instruction restores the counter from the stack.

Top module: `dsp_seq_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, `pc_o` is 0 and the return stack is empty (stack pointer 0, entries 0).
- R2: `cls_o` is one-hot and combinationally decodes `instr_i[23:22]`: value 0 (operation) sets bit 0, 1 (return) sets bit 1, 2 (jump) sets bit 2, 3 (load-immediate) sets bit 3.
- R3: After an operation or load-immediate word, `pc_o` becomes the old value plus 1, modulo 2^14 (0x3FFF wraps to 0).
- R4: In a jump word the branch code is `instr_i[21:13]`, the next address is `instr_i[12:2]` and the bank is `instr_i[1:0]`. For codes 0x080+2k, k = 0..23, the tested bit is flag index k/4 (flag inputs: bit 0 carry, 1 zero, 2 ov0, 3 ov1, 4 s0, 5 s1) of accumulator B when bit 1 of k is set, otherwise of accumulator A. The jump is taken when that bit equals bit 0 of k.
- R5: Codes 0x0B0, 0x0B1, 0x0B2 and 0x0B3 are taken when `dp_nib_i` is 0, is not 0, is 0xF and is not 0xF, in that order.
- R6: For codes 0x0B4+2j, j = 0..5, the tested bit is `stat_i[j/2]`, and the jump is taken when that bit equals bit 0 of j.
- R7: A taken conditional jump loads {bit 13 of (pc_o+1), bank, next address}. A conditional jump that is not taken loads pc_o+1.
- R8: Code 0x100 loads {0, bank, next address} and code 0x101 loads {1, bank, next address}, whatever the flags are.
- R9: Codes 0x140 and 0x141 load the same targets as 0x100 and 0x101, and they also push pc_o+1 onto the return stack.
- R10: A return-class word first decrements the 3-bit stack pointer, with wraparound over 8 entries, and then loads `pc_o` from the entry it now addresses. Pops therefore come out in last-in, first-out order, and a ninth push overwrites the oldest entry.
- R11: Branch code 0x000 loads `pc_o` from `jreg_i`.
- R12: Any other branch code leaves `pc_o` at its old value plus 1 and does not change the stack.
- R13: `take_o` is 1 exactly when the current word redirects the sequence: a return, a jump with code 0x000, 0x100, 0x101, 0x140 or 0x141, or a taken conditional jump.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_i | input | 24 | Instruction word fetched at `pc_o` |
| flag_a_i | input | 6 | Accumulator A flags {s1,s0,ov1,ov0,z,c} |
| flag_b_i | input | 6 | Accumulator B flags {s1,s0,ov1,ov0,z,c} |
| dp_nib_i | input | 4 | Low nibble of the data pointer |
| stat_i | input | 3 | Status bits: [0] input ack, [1] output ack, [2] host request |
| jreg_i | input | 14 | Register-supplied jump address |
| pc_o | output | 14 | Program counter |
| cls_o | output | 4 | One-hot instruction class of `instr_i` |
| take_o | output | 1 | Current word redirects the sequence |

## Verification
Any wrong internal state shows up on `pc_o` one clock edge after the word that uses it. A wrong flag test or target field moves the counter to the wrong address at once. A corrupted stack entry or stack pointer can stay hidden until a later return, so the bench pairs calls with returns, including nesting deeper than the stack. Every one of the 512 branch codes is swept against changing flag, nibble and status patterns. The expected counter is computed arithmetically in the bench, so a misrouted test bit shows up on the very next sample.

// File: rtl/dsp_seq_pkg.sv
package dsp_seq_pkg;
  localparam int PC_W    = 14;
  localparam int INSTR_W = 24;
  localparam int BR_W    = 9;
  localparam int NA_W    = 11;
  localparam int BANK_W  = 2;
  localparam int FLAG_W  = 6;
  localparam int STAT_W  = 3;
  localparam int NIB_W   = 4;
  localparam int CLS_N   = 4;

  typedef enum logic [1:0] {
    CLS_OP  = 2'd0,
    CLS_RET = 2'd1,
    CLS_JMP = 2'd2,
    CLS_LD  = 2'd3
  } cls_e;

  // lower 22 bits of a jump word
  typedef struct packed {
    logic [BR_W-1:0]   code;
    logic [NA_W-1:0]   na;
    logic [BANK_W-1:0] bank;
  } jfields_t;

  function automatic logic [PC_W-1:0] f_pc_inc(input logic [PC_W-1:0] pc);
    return pc + 1'b1;
  endfunction

  function automatic logic [PC_W-1:0] f_target(input logic hi,
                                                input logic [BANK_W-1:0] bank,
                                                input logic [NA_W-1:0] na);
    return {hi, bank, na};
  endfunction

  // sel[1]: compare against all-ones instead of zero; sel[0]: invert result
  function automatic logic f_nib_test(input logic [NIB_W-1:0] nib,
                                      input logic [1:0] sel);
    logic hit;
    hit = sel[1] ? (nib == {NIB_W{1'b1}}) : (nib == '0);
    return hit ^ sel[0];
  endfunction
endpackage

// File: rtl/seq_class_dec.sv
module seq_class_dec
  import dsp_seq_pkg::*;
(
  input  logic [1:0]       cls_bits_i,
  output cls_e             cls_o,
  output logic [CLS_N-1:0] onehot_o
);
  assign cls_o = cls_e'(cls_bits_i);

  for (genvar g = 0; g < CLS_N; g++) begin : g_oh
    assign onehot_o[g] = (cls_bits_i == 2'(g));
  end
endmodule

// File: rtl/seq_branch_eval.sv
module seq_branch_eval
  import dsp_seq_pkg::*;
(
  input  logic [BR_W-1:0]   code_i,
  input  logic [FLAG_W-1:0] fa_i,
  input  logic [FLAG_W-1:0] fb_i,
  input  logic [NIB_W-1:0]  nib_i,
  input  logic [STAT_W-1:0] stat_i,
  output logic              cond_take_o,
  output logic              long_o,
  output logic              long_hi_o,
  output logic              call_o,
  output logic              regjmp_o
);
  logic [4:0] k;
  logic [4:0] j;
  logic       grp_test;
  logic       sel_bit;

  always_comb begin
    k           = code_i[5:1];
    j           = k - 5'd26;
    grp_test    = (code_i[8:6] == 3'b010) && !code_i[0];
    sel_bit     = 1'b0;
    cond_take_o = 1'b0;
    regjmp_o    = (code_i == '0);
    long_o      = (code_i[8:1] == 8'h80) || (code_i[8:1] == 8'hA0);
    call_o      = (code_i[8:1] == 8'hA0);
    long_hi_o   = code_i[0];
    if (code_i[8:2] == 7'b0101100) begin
      cond_take_o = f_nib_test(nib_i, code_i[1:0]);
    end else if (grp_test && k <= 5'd23) begin
      sel_bit     = k[1] ? fb_i[k[4:2]] : fa_i[k[4:2]];
      cond_take_o = (sel_bit == k[0]);
    end else if (grp_test && k >= 5'd26) begin
      sel_bit     = stat_i[j[2:1]];
      cond_take_o = (sel_bit == j[0]);
    end
  end
endmodule

// File: rtl/seq_ret_stack.sv
module seq_ret_stack #(
  parameter int DEPTH = 8,
  parameter int DW    = 14
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     push_i,
  input  logic                     pop_i,
  input  logic [DW-1:0]            push_data_i,
  output logic [DW-1:0]            pop_data_o,
  output logic [$clog2(DEPTH)-1:0] sp_o
);
  localparam int SP_W = $clog2(DEPTH);

  logic [SP_W-1:0] sp_q;
  logic [SP_W-1:0] sp_dec;
  logic [DW-1:0]   mem [DEPTH];

  assign sp_dec = sp_q - 1'b1;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n)                             mem[g] <= '0;
      else if (push_i && sp_q == SP_W'(g))    mem[g] <= push_data_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      sp_q <= '0;
    else if (push_i) sp_q <= sp_q + 1'b1;
    else if (pop_i)  sp_q <= sp_dec;
  end

  assign pop_data_o = mem[sp_dec];
  assign sp_o       = sp_q;
endmodule

// File: rtl/dsp_seq_ctrl.sv
module dsp_seq_ctrl
  import dsp_seq_pkg::*;
#(
  parameter int STK_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [23:0]       instr_i,
  input  logic [5:0]        flag_a_i,
  input  logic [5:0]        flag_b_i,
  input  logic [3:0]        dp_nib_i,
  input  logic [2:0]        stat_i,
  input  logic [13:0]       jreg_i,
  output logic [13:0]       pc_o,
  output logic [3:0]        cls_o,
  output logic              take_o
);
  localparam int SP_W = $clog2(STK_DEPTH);

  cls_e            cls;
  jfields_t        jf;
  logic [PC_W-1:0] pc_q, pc_nxt, pc_inc, pop_pc, tgt_keep, tgt_long;
  logic [SP_W-1:0] sp_w;
  logic            cond_take, long_j, long_hi, call_j, reg_j;
  logic            is_ret, is_jmp, call_push, ret_pop, redirect;

  assign jf = jfields_t'(instr_i[21:0]);

  seq_class_dec u_dec (
    .cls_bits_i (instr_i[23:22]),
    .cls_o      (cls),
    .onehot_o   (cls_o)
  );

  seq_branch_eval u_br (
    .code_i      (jf.code),
    .fa_i        (flag_a_i),
    .fb_i        (flag_b_i),
    .nib_i       (dp_nib_i),
    .stat_i      (stat_i),
    .cond_take_o (cond_take),
    .long_o      (long_j),
    .long_hi_o   (long_hi),
    .call_o      (call_j),
    .regjmp_o    (reg_j)
  );

  assign is_ret    = (cls == CLS_RET);
  assign is_jmp    = (cls == CLS_JMP);
  assign call_push = is_jmp && call_j;
  assign ret_pop   = is_ret;

  seq_ret_stack #(.DEPTH(STK_DEPTH), .DW(PC_W)) u_stk (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (call_push),
    .pop_i       (ret_pop),
    .push_data_i (pc_inc),
    .pop_data_o  (pop_pc),
    .sp_o        (sp_w)
  );

  always_comb begin
    pc_inc   = f_pc_inc(pc_q);
    tgt_keep = f_target(pc_inc[PC_W-1], jf.bank, jf.na);
    tgt_long = f_target(long_hi, jf.bank, jf.na);
    pc_nxt   = pc_inc;
    redirect = 1'b0;
    if (is_ret) begin
      pc_nxt   = pop_pc;
      redirect = 1'b1;
    end else if (is_jmp) begin
      if (reg_j) begin
        pc_nxt   = jreg_i;
        redirect = 1'b1;
      end else if (long_j) begin
        pc_nxt   = tgt_long;
        redirect = 1'b1;
      end else if (cond_take) begin
        pc_nxt   = tgt_keep;
        redirect = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_nxt;
  end

  assign pc_o   = pc_q;
  assign take_o = redirect;
endmodule

// File: rtl/seq_ctrl_chk.sv
module seq_ctrl_chk #(
  parameter int SP_W = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic [23:0]     instr_i,
  input logic [13:0]     jreg_i,
  input logic [13:0]     pc_o,
  input logic [3:0]      cls_o,
  input logic            take_o,
  input logic            call_push,
  input logic            ret_pop,
  input logic [SP_W-1:0] sp_w
);
  logic is_jmp_w;
  assign is_jmp_w = (instr_i[23:22] == 2'd2);

  assert_reset_pc_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pc_o == 14'd0 && sp_w == '0));

  assert_class_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cls_o) == 1);

  assert_seq_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_o[0] || cls_o[3]) |=> pc_o == $past(pc_o) + 14'd1);

  assert_long_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (is_jmp_w && instr_i[21:13] == 9'h100) |=> !pc_o[13]);

  assert_long_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (is_jmp_w && instr_i[21:13] == 9'h101) |=> pc_o[13]);

  assert_push_grows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    call_push |=> sp_w == $past(sp_w) + 1'b1);

  assert_pop_shrinks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ret_pop |=> sp_w == $past(sp_w) - 1'b1);

  assert_call_ret_pair_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_pop && $past(call_push)) |=> pc_o == $past(pc_o, 2) + 14'd1);

  assert_reg_jump_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (is_jmp_w && instr_i[21:13] == 9'h000) |=> pc_o == $past(jreg_i));

  assert_no_take_steps_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !take_o |=> pc_o == $past(pc_o) + 14'd1);

  assert_ret_takes_R13: assert property (@(posedge clk) disable iff (!rst_n)
    ret_pop |-> take_o);
endmodule

bind dsp_seq_ctrl seq_ctrl_chk #(.SP_W(SP_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .instr_i   (instr_i),
  .jreg_i    (jreg_i),
  .pc_o      (pc_o),
  .cls_o     (cls_o),
  .take_o    (take_o),
  .call_push (call_push),
  .ret_pop   (ret_pop),
  .sp_w      (sp_w)
);

// File: tb/tb_dsp_seq_ctrl.sv
`timescale 1ns/1ps
module tb_dsp_seq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] instr_i = '0;
  logic [5:0]  flag_a_i = '0, flag_b_i = '0;
  logic [3:0]  dp_nib_i = '0;
  logic [2:0]  stat_i = '0;
  logic [13:0] jreg_i = '0;
  logic [13:0] pc_o;
  logic [3:0]  cls_o;
  logic        take_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int exp_pc = 0, exp_sp = 0;
  int exp_stk [8];
  int lcg = 12345;

  dsp_seq_ctrl dut (.*);

  always #4 clk = ~clk;  // 125 MHz

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic int rnd();
    lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
    return lcg >>> 8;
  endfunction

  function automatic logic [23:0] mk_jmp(input int code, input int bank, input int na);
    return {2'b10, 9'(code), 11'(na), 2'(bank)};
  endfunction

  // expected outcome of a jump word, from the requirements
  task automatic jmp_model(input int code, input int bank, input int na,
                           output int nxt, output bit push, output bit tk, output string tag);
    int inc, low, f;
    inc = (exp_pc + 1) % 16384;
    low = bank * 2048 + na;
    nxt = inc; push = 0; tk = 0; tag = "R12";
    if (code == 0) begin
      nxt = jreg_i; tk = 1; tag = "R11";
    end else if (code == 256 || code == 257 || code == 320 || code == 321) begin
      nxt = (code % 2) * 8192 + low; tk = 1;
      push = (code >= 320); tag = push ? "R9" : "R8";
    end else begin
      if (code >= 128 && code <= 174 && code % 2 == 0) begin
        int k = (code - 128) / 2;
        f = ((k / 2) % 2 == 1) ? flag_b_i[k / 4] : flag_a_i[k / 4];
        tk = (f == k % 2); tag = "R4";
      end else if (code >= 176 && code <= 179) begin
        case (code - 176)
          0: tk = (dp_nib_i == 0);
          1: tk = (dp_nib_i != 0);
          2: tk = (dp_nib_i == 15);
          default: tk = (dp_nib_i != 15);
        endcase
        tag = "R5";
      end else if (code >= 180 && code <= 190 && code % 2 == 0) begin
        int jj = (code - 180) / 2;
        f = stat_i[jj / 2];
        tk = (f == jj % 2); tag = "R6";
      end
      if (tk) nxt = (inc / 8192) * 8192 + low;  // R7
    end
  endtask

  task automatic run(input logic [23:0] ins);
    int nxt, cls; bit push, tk; string tag;
    instr_i = ins;
    cls = int'(ins[23:22]);
    push = 0; tk = 0; nxt = (exp_pc + 1) % 16384; tag = "R3";
    if (cls == 2) jmp_model(int'(ins[21:13]), int'(ins[1:0]), int'(ins[12:2]), nxt, push, tk, tag);
    else if (cls == 1) begin
      exp_sp = (exp_sp + 7) % 8;
      nxt = exp_stk[exp_sp]; tk = 1; tag = "R10";
    end
    #1;
    chk("R2 cls_o", int'(cls_o), 1 << cls);
    chk({"R13 take_o ", tag}, int'(take_o), int'(tk));
    if (push) begin
      exp_stk[exp_sp] = (exp_pc + 1) % 16384;
      exp_sp = (exp_sp + 1) % 8;
    end
    @(negedge clk);
    chk({tag, " pc_o"}, int'(pc_o), nxt);
    if (tag == "R4" || tag == "R5" || tag == "R6") chk("R7 pc_o", int'(pc_o), nxt);
    exp_pc = nxt;
  endtask

  initial begin
    #1600000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    foreach (exp_stk[i]) exp_stk[i] = 0;
    repeat (3) @(negedge clk);
    chk("R1 pc_o in reset", int'(pc_o), 0);
    rst_n = 1'b1;
    chk("R1 pc_o after reset", int'(pc_o), 0);

    // R3: operation and load-immediate steps
    for (int i = 0; i < 6; i++) run({(i % 2) ? 2'd3 : 2'd0, 22'(rnd())});
    // R3 wrap at the top of the space
    run(mk_jmp(257, 3, 2047));
    run({2'd3, 22'h0});
    chk("R3 wrap", int'(pc_o), 0);
    // R7: incremented bit 13 used for the kept half
    run(mk_jmp(256, 3, 2047));
    dp_nib_i = 0;
    run(mk_jmp(176, 0, 5));
    chk("R7 half crossing", int'(pc_o), 14'h2005);

    // R10: nested calls and returns, then deeper than the stack
    for (int i = 0; i < 3; i++) run(mk_jmp(320 + i % 2, i, 100 * i + 7));
    for (int i = 0; i < 3; i++) run({2'd1, 22'(rnd())});
    for (int i = 0; i < 10; i++) run(mk_jmp(320 + i % 2, i % 4, 37 * i + 1));
    for (int i = 0; i < 10; i++) run({2'd0 + 2'd1, 22'(rnd())});

    // R5: every nibble against each data-pointer test
    for (int n = 0; n < 16; n++)
      for (int c = 176; c < 180; c++) begin
        dp_nib_i = 4'(n);
        run(mk_jmp(c, n % 4, n * 13));
      end

    // R4 R6 R8 R9 R11 R12: all branch codes under varied inputs
    for (int p = 0; p < 4; p++)
      for (int c = 0; c < 512; c++) begin
        int r = rnd();
        flag_a_i = 6'(r);
        flag_b_i = 6'(r >> 6);
        dp_nib_i = 4'(r >> 12);
        stat_i   = 3'(r >> 16);
        jreg_i   = 14'(rnd());
        run(mk_jmp(c, (c + p) % 4, (rnd() % 2048)));
      end
    // drain the stack with returns (R10)
    for (int i = 0; i < 8; i++) run({2'd1, 22'h0});

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule